// File: doc/BRIEF.md
# Nested priority interrupt arbiter

This block sits between a set of level-sensitive interrupt request lines and a processor core. Each source carries a priority level that software writes through a small register port, normally once at start-up. The arbiter keeps a running level for the code now executing. At every instruction start that the core signals, it selects the most urgent pending request and grants it only if that request outranks the running level.

A grant produces a one-cycle take strobe together with the winning source index, its level, and a per-source acknowledge pulse. On a grant the running level is pushed onto a small stack of saved levels and then raised to the granted level. A handler-complete strobe pops the stack and restores the level that was interrupted. As a result, more urgent sources can preempt a running handler, while sources of equal or lower urgency wait for it to finish.

A global mask input holds off every grant while a handler saves its critical state. Level 0 is the running level of user code. A source programmed to level 0 never wins.

Top module: `nest_irq_arbiter`

## Requirements
- R1: A grant is issued only when the winning request's level is strictly greater than the running level. A pending request at an equal or lower level gets no grant.
- R2: Arbitration happens only on a clock edge where `insn_start` is high. `take`, `take_src`, `take_level` and `src_ack` are registered and appear in the cycle after that edge.
- R3: Each source has a PRIO_W-bit level register. All of them reset to 0, and a write to one changes only that source. A source whose level is 0 is never granted.
- R4: Among pending enabled requests, the highest level wins. Between requests at the same level, the lowest source index wins.
- R5: On a grant, the running level becomes the granted level in the same cycle that `take` is high, and the previous running level is saved.
- R6: A `handler_done` edge with a non-empty stack restores the most recently saved level. No grant is made on that edge. A `handler_done` with an empty stack leaves the running level unchanged.
- R7: While `mask_all` is high, no grant is made. After it clears, only requests that outrank the running level are granted.
- R8: `src_ack` is one-hot with bit `take_src` set during a `take` cycle, and zero otherwise. Requests are level-sensitive: a request that is held stays pending until it is granted.
- R9: When the stack already holds STACK_DEPTH levels, a grant that would otherwise occur is refused and `nest_ovf` is set. `nest_ovf` stays set until reset.
- R10: After reset, `take`, `src_ack` and `nest_ovf` are 0, the running level is 0 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Level-sensitive request lines |
| prio_wr_en | input | 1 | Write strobe for a source level |
| prio_wr_idx | input | $clog2(NUM_SRC) | Source whose level is written |
| prio_wr_level | input | PRIO_W | Level value written (0 disables) |
| insn_start | input | 1 | Core is at an instruction boundary |
| mask_all | input | 1 | Hold off all grants |
| handler_done | input | 1 | Current handler finished; restore level |
| take | output | 1 | One-cycle grant strobe |
| take_src | output | $clog2(NUM_SRC) | Granted source index |
| take_level | output | PRIO_W | Granted level |
| run_level | output | PRIO_W | Level of the code now running |
| src_ack | output | NUM_SRC | One-hot acknowledge to the granted source |
| nest_ovf | output | 1 | Sticky nesting overflow flag |

## Verification
The assertions check several relations on every cycle. Each grant must strictly outrank the level that was running before it, it must follow an unmasked instruction start, and the running level must move to the granted level. The acknowledge must match the granted index. A pop must lower the level, a pop on an empty stack must change nothing, and the overflow flag must be sticky and must set only when the stack is full. Some behaviour can be shown only by the bench's scenarios, which compare each grant against a queue of expected grants: the choice of winner among several pending sources, the lowest-index tie rule, disabled sources, a request that stays pending across a pop, and the exact level restored after each pop.

// File: rtl/nia_pkg.sv
// Package: shared types for the nested priority interrupt arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package nia_pkg;
    // Operation applied to the saved-level stack on a clock edge
    typedef enum logic [1:0] {
        STK_NONE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/nia_prio_regs.sv
// Module: per-source priority level registers written by software.
// Assumes: one write per cycle; index values at or above NUM_SRC are ignored.
module nia_prio_regs #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SRC_W-1:0]            wr_idx,
    input  logic [PRIO_W-1:0]           wr_level,
    output logic [NUM_SRC*PRIO_W-1:0]   levels
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [PRIO_W-1:0] lvl_q;
        // Hold one source's level; load it when this index is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q <= '0;
            else if (wr_en && wr_idx == SRC_W'(g))
                lvl_q <= wr_level;
        end
        assign levels[g*PRIO_W +: PRIO_W] = lvl_q;
    end
endmodule

// File: rtl/nia_select.sv
// Module: combinational winner search over pending requests.
// Picks the highest nonzero level; ties go to the lowest index.
// Assumes: level 0 means the source is disabled.
module nia_select #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]          req,
    input  logic [NUM_SRC*PRIO_W-1:0]   levels,
    output logic                        any,
    output logic [SRC_W-1:0]            win_idx,
    output logic [PRIO_W-1:0]           win_level
);
    // Scan upward; only a strictly higher level replaces the best so far
    always_comb begin
        logic [PRIO_W-1:0] cur;
        win_idx   = '0;
        win_level = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            cur = levels[i*PRIO_W +: PRIO_W];
            if (req[i] && cur > win_level) begin
                win_level = cur;
                win_idx   = SRC_W'(i);
            end
        end
        any = (win_level != '0);
    end
endmodule

// File: rtl/nia_level_stack.sv
// Module: fixed-depth LIFO of saved running levels.
// Assumes: the caller never pushes when full or pops when empty.
// Such requests are ignored here as a guard.
module nia_level_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  nia_pkg::stk_op_e     op,
    input  logic [PRIO_W-1:0]    push_level,
    output logic [PRIO_W-1:0]    top_level,
    output logic [CNT_W-1:0]     count
);
    import nia_pkg::*;

    logic [PRIO_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  top_ptr;

    assign wr_ptr  = PTR_W'(cnt_q);
    assign top_ptr = PTR_W'(cnt_q - CNT_W'(1));

    // Track occupancy and store the pushed level at the next free slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (op == STK_PUSH && cnt_q < CNT_W'(DEPTH)) begin
                mem[wr_ptr] <= push_level;
                cnt_q       <= cnt_q + CNT_W'(1);
            end else if (op == STK_POP && cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // Present the most recently saved level, or 0 when empty
    always_comb top_level = (cnt_q != '0) ? mem[top_ptr] : '0;

    assign count = cnt_q;
endmodule

// File: rtl/nest_irq_arbiter.sv
// Module: nested priority interrupt arbiter (top).
// Grants a request at an instruction start when it outranks the running
// level, saves that level on a stack and restores it on handler completion.
// Assumes: handler_done is a one-cycle strobe from the core; a pop has
// precedence over a grant on the same edge.
module nest_irq_arbiter #(
    parameter int NUM_SRC     = 8,
    parameter int PRIO_W      = 3,
    parameter int STACK_DEPTH = 8,
    localparam int SRC_W      = $clog2(NUM_SRC),
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_req,
    input  logic                prio_wr_en,
    input  logic [SRC_W-1:0]    prio_wr_idx,
    input  logic [PRIO_W-1:0]   prio_wr_level,
    input  logic                insn_start,
    input  logic                mask_all,
    input  logic                handler_done,
    output logic                take,
    output logic [SRC_W-1:0]    take_src,
    output logic [PRIO_W-1:0]   take_level,
    output logic [PRIO_W-1:0]   run_level,
    output logic [NUM_SRC-1:0]  src_ack,
    output logic                nest_ovf
);
    import nia_pkg::*;

    logic [NUM_SRC*PRIO_W-1:0] levels;
    logic                      any_req;
    logic [SRC_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_level;
    logic [PRIO_W-1:0]         saved_level;
    logic [CNT_W-1:0]          stk_count;
    logic                      want_take;
    logic                      stk_full;
    logic                      do_take;
    logic                      do_pop;
    stk_op_e                   stk_op;
    logic [PRIO_W-1:0]         run_q;

    nia_prio_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (prio_wr_en),
        .wr_idx   (prio_wr_idx),
        .wr_level (prio_wr_level),
        .levels   (levels)
    );

    nia_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_sel (
        .req       (irq_req),
        .levels    (levels),
        .any       (any_req),
        .win_idx   (win_idx),
        .win_level (win_level)
    );

    nia_level_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (stk_op),
        .push_level (run_q),
        .top_level  (saved_level),
        .count      (stk_count)
    );

    // Decide this edge's action: pop first, then an outranking grant
    always_comb begin
        want_take = insn_start && !mask_all && !handler_done
                    && any_req && (win_level > run_q);
        stk_full  = (stk_count == CNT_W'(STACK_DEPTH));
        do_take   = want_take && !stk_full;
        do_pop    = handler_done && (stk_count != '0);
        stk_op    = do_pop ? STK_POP : (do_take ? STK_PUSH : STK_NONE);
    end

    // Running level: raise on a grant, restore on a pop
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (do_pop)
            run_q <= saved_level;
        else if (do_take)
            run_q <= win_level;
    end

    // Registered grant outputs and per-source acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take       <= 1'b0;
            take_src   <= '0;
            take_level <= '0;
            src_ack    <= '0;
        end else begin
            take    <= do_take;
            src_ack <= do_take ? (NUM_SRC'(1) << win_idx) : '0;
            if (do_take) begin
                take_src   <= win_idx;
                take_level <= win_level;
            end
        end
    end

    // Sticky overflow: a grant was due but the stack had no room
    always_ff @(posedge clk) begin
        if (!rst_n)
            nest_ovf <= 1'b0;
        else if (want_take && stk_full)
            nest_ovf <= 1'b1;
    end

    assign run_level = run_q;
endmodule

// File: rtl/nia_checker.sv
// Module: assertion checker for nest_irq_arbiter, attached by bind.
// Assumes: connected to the top's ports and its stack occupancy.
module nia_checker #(
    parameter int NUM_SRC     = 8,
    parameter int PRIO_W      = 3,
    parameter int STACK_DEPTH = 8,
    localparam int SRC_W      = $clog2(NUM_SRC),
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                insn_start,
    input logic                mask_all,
    input logic                handler_done,
    input logic                take,
    input logic [SRC_W-1:0]    take_src,
    input logic [PRIO_W-1:0]   take_level,
    input logic [PRIO_W-1:0]   run_level,
    input logic [NUM_SRC-1:0]  src_ack,
    input logic                nest_ovf,
    input logic [CNT_W-1:0]    stk_count
);
    assert_take_outranks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> take_level > $past(run_level));

    assert_take_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(insn_start && !handler_done));

    assert_take_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !$past(mask_all));

    assert_level_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> run_level == take_level);

    assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack) && (take || src_ack == '0));

    assert_ack_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> src_ack == (NUM_SRC'(1) << take_src));

    assert_pop_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_done && stk_count != '0) |=> (run_level < $past(run_level)) && !take);

    assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_done && stk_count == '0) |=> $stable(run_level) && !take);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nest_ovf |=> nest_ovf);

    assert_ovf_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nest_ovf) |-> $past(stk_count) == CNT_W'(STACK_DEPTH));

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_count <= CNT_W'(STACK_DEPTH));
endmodule

bind nest_irq_arbiter nia_checker #(
    .NUM_SRC     (NUM_SRC),
    .PRIO_W      (PRIO_W),
    .STACK_DEPTH (STACK_DEPTH)
) u_nia_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_start   (insn_start),
    .mask_all     (mask_all),
    .handler_done (handler_done),
    .take         (take),
    .take_src     (take_src),
    .take_level   (take_level),
    .run_level    (run_level),
    .src_ack      (src_ack),
    .nest_ovf     (nest_ovf),
    .stk_count    (stk_count)
);

// File: tb/nest_irq_arbiter_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected grants; a monitor compares every take.
module nest_irq_arbiter_bench;
    localparam int NSRC  = 8;
    localparam int PW    = 3;
    localparam int DEPTH = 4;
    localparam int SW    = $clog2(NSRC);

    typedef struct { int src; int lvl; } grant_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic            prio_wr_en = 1'b0;
    logic [SW-1:0]   prio_wr_idx = '0;
    logic [PW-1:0]   prio_wr_level = '0;
    logic            insn_start = 1'b0;
    logic            mask_all = 1'b0;
    logic            handler_done = 1'b0;
    logic            take;
    logic [SW-1:0]   take_src;
    logic [PW-1:0]   take_level;
    logic [PW-1:0]   run_level;
    logic [NSRC-1:0] src_ack;
    logic            nest_ovf;

    int     checks = 0;
    int     errors = 0;
    bit     done   = 0;
    grant_t exp_q[$];

    nest_irq_arbiter #(.NUM_SRC(NSRC), .PRIO_W(PW), .STACK_DEPTH(DEPTH)) u_nest_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .prio_wr_en(prio_wr_en), .prio_wr_idx(prio_wr_idx), .prio_wr_level(prio_wr_level),
        .insn_start(insn_start), .mask_all(mask_all), .handler_done(handler_done),
        .take(take), .take_src(take_src), .take_level(take_level),
        .run_level(run_level), .src_ack(src_ack), .nest_ovf(nest_ovf)
    );

    always #2.5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_take(int src, int lvl);
        grant_t g;
        g.src = src;
        g.lvl = lvl;
        exp_q.push_back(g);
    endtask

    task automatic set_level(int idx, int lvl);
        prio_wr_en    = 1'b1;
        prio_wr_idx   = SW'(idx);
        prio_wr_level = PW'(lvl);
        step();
        prio_wr_en = 1'b0;
    endtask

    task automatic pop();
        handler_done = 1'b1;
        step();
        handler_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: every take must match the next expected grant (R1 R2 R4 R8)
    always @(negedge clk) begin
        if (rst_n && take) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R1 unexpected take actual src=%0d lvl=%0d expected=none",
                         take_src, take_level);
            end else begin
                grant_t g;
                g = exp_q.pop_front();
                check_eq("R4 take_src", int'(take_src), g.src);
                check_eq("R2 take_level", int'(take_level), g.lvl);
                check_eq("R8 src_ack", int'(src_ack), 1 << g.src);
            end
        end
    end

    // Watchdog: a hung run counts as one failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10 reset state
        check_eq("R10 take", int'(take), 0);
        check_eq("R10 run_level", int'(run_level), 0);
        check_eq("R10 nest_ovf", int'(nest_ovf), 0);
        check_eq("R10 src_ack", int'(src_ack), 0);

        // R3 program levels: src3 stays 0 (disabled)
        set_level(0, 2); set_level(1, 5); set_level(2, 5); set_level(4, 3);
        set_level(5, 7); set_level(6, 1); set_level(7, 4);

        // R3 a disabled source is never taken
        irq_req = 8'b0000_1000;
        insn_start = 1'b1;
        repeat (3) step();
        check_eq("R3 disabled source run_level", int'(run_level), 0);
        irq_req = '0;

        // R2 no arbitration without instruction start; R8 request stays pending
        insn_start = 1'b0;
        irq_req = 8'b0001_0000;
        repeat (3) step();
        check_eq("R2 no start run_level", int'(run_level), 0);
        insn_start = 1'b1;
        expect_take(4, 3);
        step();
        check_eq("R5 raised level", int'(run_level), 3);

        // R1 equal and lower levels wait
        repeat (2) step();
        irq_req = 8'b0001_0001;
        repeat (2) step();
        check_eq("R1 equal/lower wait run_level", int'(run_level), 3);
        irq_req = '0;

        // R7 mask holds off even the top level
        mask_all = 1'b1;
        irq_req = 8'b0010_0001;
        repeat (3) step();
        check_eq("R7 masked run_level", int'(run_level), 3);
        mask_all = 1'b0;
        expect_take(5, 7);
        step();
        check_eq("R5 preempt level", int'(run_level), 7);

        // R6 pop restores; no grant on the pop edge; R4 tie goes to lowest index
        irq_req = 8'b0000_0110;
        step();
        pop();
        check_eq("R6 restored level", int'(run_level), 3);
        check_eq("R6 no take on pop edge", int'(take), 0);
        expect_take(1, 5);
        step();
        check_eq("R4 tie level", int'(run_level), 5);
        irq_req = 8'b0000_0100;
        repeat (2) step();
        check_eq("R1 equal tie waits", int'(run_level), 5);
        pop();
        check_eq("R6 restored after tie", int'(run_level), 3);
        expect_take(2, 5);
        step();
        irq_req = '0;
        pop();
        check_eq("R6 second pop", int'(run_level), 3);
        pop();
        check_eq("R6 back to user level", int'(run_level), 0);
        pop();
        check_eq("R6 pop on empty ignored", int'(run_level), 0);
        check_eq("R6 empty pop no overflow", int'(nest_ovf), 0);

        // R4 highest level wins among several at once
        irq_req = 8'b1100_0001;
        expect_take(7, 4);
        step();
        irq_req = '0;
        pop();
        check_eq("R4 after winner pop", int'(run_level), 0);

        // R9 nest to full depth, then one more is refused
        irq_req = 8'b0100_0000; expect_take(6, 1); step();
        irq_req = 8'b0000_0001; expect_take(0, 2); step();
        irq_req = 8'b0001_0000; expect_take(4, 3); step();
        irq_req = 8'b1000_0000; expect_take(7, 4); step();
        check_eq("R9 full level", int'(run_level), 4);
        check_eq("R9 no overflow yet", int'(nest_ovf), 0);
        irq_req = 8'b0000_0010;
        repeat (2) step();
        check_eq("R9 refused level", int'(run_level), 4);
        check_eq("R9 overflow set", int'(nest_ovf), 1);
        irq_req = '0;
        pop(); check_eq("R6 unwind 1", int'(run_level), 3);
        pop(); check_eq("R6 unwind 2", int'(run_level), 2);
        pop(); check_eq("R6 unwind 3", int'(run_level), 1);
        pop(); check_eq("R6 unwind 4", int'(run_level), 0);
        check_eq("R9 overflow sticky", int'(nest_ovf), 1);

        step();
        check_eq("R2 all expected grants seen", exp_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule